// File: doc/BRIEF.md
# Retriggerable Watchdog Timer

This block guards a system against software that has stopped running its main loop. It stays idle after reset until software issues its first refresh command. That refresh arms the timer. From then on the timer counts ticks of a slow, free-running oscillator. Each tick arrives as a one-cycle enable strobe in the system clock domain. If the count reaches the terminal value before the next refresh, the block emits a one-cycle system-reset pulse and disarms itself. Every refresh restarts the count from zero.

The terminal value comes from a two-bit selection held in a small mode register. With the default parameters the selections give 2^10, 2^12, 2^14 and 2^16 ticks. The mode register takes writes only during a short window of system clocks that opens at reset. After the window closes the selection is frozen until the next reset, so a runaway program cannot lengthen the timeout. A status output shows whether the timer is currently armed.

Top module: `wdt_top`

## Requirements
- R1: After a synchronous reset the timer is disarmed (`wdt_armed` = 0), `wdt_rst_pulse` is 0 and the selection is 0, which is the shortest timeout.
- R2: While disarmed, oscillator ticks have no effect: no reset pulse is produced and `wdt_armed` stays 0.
- R3: A refresh arms the timer; `wdt_armed` reads 1 from the cycle after the refresh.
- R4: Once armed, the timer fires after exactly 2^(BASE_LOG + STEP_LOG*sel) ticks. `sel` is the two-bit selection, with bit 1 and bit 0 taken from `mode_wdata[1]` and `mode_wdata[0]`. The pulse appears in the cycle after the edge that samples the final tick. Clocks without a tick do not advance the count.
- R5: A refresh while armed restarts the count from zero, so the full timeout is needed again.
- R6: `wdt_rst_pulse` is high for exactly one cycle, and `wdt_armed` reads 0 in that same cycle. Later ticks produce no pulse until the next refresh.
- R7: A write on `mode_wr` is accepted when it is sampled on one of the first WIN_CYCLES clock edges after reset is released, counting from edge 0.
- R8: Writes sampled on edge WIN_CYCLES or later are ignored, and the timeout keeps its earlier selection.
- R9: When a refresh and a tick arrive in the same cycle, the refresh wins: no pulse occurs and the count restarts from zero.
- R10: A reset in the middle of a count disarms the timer and reopens the write window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator tick |
| refresh | input | 1 | Refresh command strobe; arms the timer and restarts the count |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | SEL_W | Timeout selection to write |
| wdt_rst_pulse | output | 1 | One-cycle system-reset request |
| wdt_armed | output | 1 | Timer armed status |

## Verification
The bench sweeps all four selections and counts every tick up to the terminal value. A design with an off-by-one limit fires a tick early or late, and one that counts clocks instead of ticks fires long before the expected moment. It writes on the last edge inside the window and again on the first edge after it. A window that is one clock too short or too long then shows up as the wrong timeout length. It issues a refresh in the same cycle as the tick that would have fired, and it keeps ticking after a pulse. This exposes a design that lets the tick win, or one that stays armed and fires again.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // log2 of the terminal tick count for one selection value
  function automatic int unsigned wdt_term_log(input int unsigned base_log,
                                               input int unsigned step_log,
                                               input int unsigned sel);
    return base_log + step_log * sel;
  endfunction

  // widest count needed over all selections
  function automatic int unsigned wdt_max_log(input int unsigned base_log,
                                              input int unsigned step_log,
                                              input int unsigned sel_w);
    return base_log + step_log * ((1 << sel_w) - 1);
  endfunction

endpackage

// File: rtl/wdt_mode.sv
module wdt_mode #(
  parameter int unsigned WIN_CYCLES = 64,
  parameter int unsigned SEL_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [SEL_W-1:0] wdata,
  output logic [SEL_W-1:0] sel
);
  localparam int unsigned WIN_W = $clog2(WIN_CYCLES + 1);
  localparam logic [WIN_W-1:0] WIN_END = WIN_W'(WIN_CYCLES);

  logic [WIN_W-1:0] win_cnt;
  logic             win_open;

  assign win_open = (win_cnt < WIN_END);

  // saturating count of clocks since reset
  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
    end else if (win_open) begin
      win_cnt <= win_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
    end else if (wr && win_open) begin
      sel <= wdata;
    end
  end

  // once closed, the window stays closed until reset
  assert_window_monotonic_R7: assert property (@(posedge clk) disable iff (rst)
    !win_open |=> !win_open);

  // selection frozen after the window
  assert_locked_after_window_R8: assert property (@(posedge clk) disable iff (rst)
    !win_open |=> $stable(sel));

endmodule

// File: rtl/wdt_limit.sv
module wdt_limit
  import wdt_pkg::*;
#(
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned BASE_LOG = 10,
  parameter int unsigned STEP_LOG = 2,
  parameter int unsigned CNT_W    = 16
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] limit_m1
);
  localparam int unsigned NSEL = 1 << SEL_W;

  logic [CNT_W-1:0] lim_tab [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    localparam int unsigned LOGT = wdt_term_log(BASE_LOG, STEP_LOG, g);
    assign lim_tab[g] = CNT_W'((64'd1 << LOGT) - 64'd1);
  end

  assign limit_m1 = lim_tab[sel];

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             refresh,
  input  logic [CNT_W-1:0] limit_m1,
  output logic             armed,
  output logic             fire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
      fire  <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (refresh) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed && tick) begin
        if (cnt >= limit_m1) begin
          fire  <= 1'b1;
          armed <= 1'b0;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_refresh_arms_R3: assert property (@(posedge clk) disable iff (rst)
    refresh |=> armed && (cnt == '0));

  assert_fire_needs_tick_R4: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(armed) && $past(tick) && !$past(refresh));

  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (armed && !tick && !refresh) |=> armed && $stable(cnt));

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);

  assert_fire_disarms_R6: assert property (@(posedge clk) disable iff (rst)
    fire |-> !armed);

  assert_refresh_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (refresh && tick) |=> !fire);

endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 64,
  parameter int unsigned SEL_W      = 2,
  parameter int unsigned BASE_LOG   = 10,
  parameter int unsigned STEP_LOG   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_tick,
  input  logic             refresh,
  input  logic             mode_wr,
  input  logic [SEL_W-1:0] mode_wdata,
  output logic             wdt_rst_pulse,
  output logic             wdt_armed
);
  localparam int unsigned CNT_W = wdt_max_log(BASE_LOG, STEP_LOG, SEL_W);

  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] limit_m1;

  wdt_mode #(
    .WIN_CYCLES(WIN_CYCLES),
    .SEL_W     (SEL_W)
  ) u_mode (
    .clk  (clk),
    .rst  (rst),
    .wr   (mode_wr),
    .wdata(mode_wdata),
    .sel  (sel)
  );

  wdt_limit #(
    .SEL_W   (SEL_W),
    .BASE_LOG(BASE_LOG),
    .STEP_LOG(STEP_LOG),
    .CNT_W   (CNT_W)
  ) u_limit (
    .sel     (sel),
    .limit_m1(limit_m1)
  );

  wdt_count #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk     (clk),
    .rst     (rst),
    .tick    (osc_tick),
    .refresh (refresh),
    .limit_m1(limit_m1),
    .armed   (wdt_armed),
    .fire    (wdt_rst_pulse)
  );

  assert_pulse_needs_arm_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst_pulse) |-> $past(wdt_armed));

endmodule

// File: tb/wdt_top_tb.sv
module wdt_top_tb;
  localparam int unsigned WIN  = 16;
  localparam int unsigned BASE = 3;
  localparam int unsigned STEP = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_tick = 1'b0;
  logic       refresh = 1'b0;
  logic       mode_wr = 1'b0;
  logic [1:0] mode_wdata = 2'd0;
  logic       wdt_rst_pulse;
  logic       wdt_armed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdt_top #(
    .WIN_CYCLES(WIN),
    .SEL_W     (2),
    .BASE_LOG  (BASE),
    .STEP_LOG  (STEP)
  ) u_dut (
    .clk          (clk),
    .rst          (rst),
    .osc_tick     (osc_tick),
    .refresh      (refresh),
    .mode_wr      (mode_wr),
    .mode_wdata   (mode_wdata),
    .wdt_rst_pulse(wdt_rst_pulse),
    .wdt_armed    (wdt_armed)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // drive inputs for one clock, return at the following negedge
  task automatic cyc(input logic t, input logic r, input logic w, input logic [1:0] d);
    osc_tick = t; refresh = r; mode_wr = w; mode_wdata = d;
    @(negedge clk);
    osc_tick = 1'b0; refresh = 1'b0; mode_wr = 1'b0; mode_wdata = 2'd0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    rst = 1'b0;
  endtask

  function automatic int unsigned term(input int unsigned s);
    return 1 << (BASE + STEP * s);
  endfunction

  // refresh, then tick to the timeout with idle gaps between ticks
  task automatic run_timeout(input int unsigned t, input string req);
    cyc(0, 1, 0, 0);
    check("R3", "armed after refresh", wdt_armed, 1'b1);
    for (int unsigned i = 1; i <= t; i++) begin
      cyc(1, 0, 0, 0);
      if (i < t) begin
        if (wdt_rst_pulse !== 1'b0 || wdt_armed !== 1'b1) begin
          check(req, "early pulse or disarm", wdt_rst_pulse, 1'b0);
          check(req, "armed while counting", wdt_armed, 1'b1);
        end
        if (i % 3 == 0) begin
          cyc(0, 0, 0, 0);
          check("R4", "idle clock no pulse", wdt_rst_pulse, 1'b0);
        end
      end else begin
        check(req, "pulse at terminal tick", wdt_rst_pulse, 1'b1);
        check("R6", "disarmed with pulse", wdt_armed, 1'b0);
      end
    end
    cyc(0, 0, 0, 0);
    check("R6", "pulse one cycle", wdt_rst_pulse, 1'b0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1", "armed after reset", wdt_armed, 1'b0);
    check("R1", "pulse after reset", wdt_rst_pulse, 1'b0);

    // R2 ticks while disarmed
    for (int i = 0; i < 100; i++) begin
      cyc(1, 0, 0, 0);
      if (wdt_rst_pulse !== 1'b0 || wdt_armed !== 1'b0)
        check("R2", "disarmed ticks", wdt_rst_pulse | wdt_armed, 1'b0);
    end
    check("R2", "still disarmed", wdt_armed, 1'b0);

    // R1 default selection is the shortest
    do_reset();
    run_timeout(term(0), "R1");

    // R4/R7 sweep all selections written inside the window
    for (int unsigned s = 0; s < 4; s++) begin
      do_reset();
      cyc(0, 0, 1, 2'(s));
      run_timeout(term(s), "R4");
    end

    // R7 write on the last edge inside the window
    do_reset();
    repeat (WIN - 1) cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 2'd1);
    run_timeout(term(1), "R7");

    // R8 write on the first edge after the window
    do_reset();
    repeat (WIN) cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 2'd3);
    run_timeout(term(0), "R8");

    // R8 later write cannot undo an accepted one
    do_reset();
    cyc(0, 0, 1, 2'd3);
    repeat (WIN) cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 2'd0);
    run_timeout(term(3), "R8");

    // R6 no pulse after firing until refreshed
    for (int i = 0; i < 2 * int'(term(0)); i++) begin
      cyc(1, 0, 0, 0);
      if (wdt_rst_pulse !== 1'b0) check("R6", "pulse after fire", wdt_rst_pulse, 1'b0);
    end
    check("R6", "stays disarmed", wdt_armed, 1'b0);

    // R5 refresh in mid count restarts
    do_reset();
    cyc(0, 1, 0, 0);
    repeat (5) cyc(1, 0, 0, 0);
    check("R5", "no pulse mid count", wdt_rst_pulse, 1'b0);
    run_timeout(term(0), "R5");

    // R9 refresh together with the terminal tick
    do_reset();
    cyc(0, 1, 0, 0);
    repeat (term(0) - 1) cyc(1, 0, 0, 0);
    cyc(1, 1, 0, 0);
    check("R9", "no pulse on refresh+tick", wdt_rst_pulse, 1'b0);
    check("R9", "armed on refresh+tick", wdt_armed, 1'b1);
    repeat (term(0) - 1) cyc(1, 0, 0, 0);
    check("R9", "no pulse before full count", wdt_rst_pulse, 1'b0);
    cyc(1, 0, 0, 0);
    check("R9", "pulse after full count", wdt_rst_pulse, 1'b1);

    // R10 reset in mid count, window reopens
    cyc(0, 1, 0, 0);
    repeat (3) cyc(1, 0, 0, 0);
    do_reset();
    check("R10", "disarmed by reset", wdt_armed, 1'b0);
    cyc(0, 0, 1, 2'd2);
    run_timeout(term(2), "R10");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule